// File: doc/BRIEF.md
# Protection Region Register Bank

This block holds the region descriptors of a memory-protection unit. It keeps two banks, one owned by the operating-system level and one owned by the hypervisor level. Each bank stores a 32-bit base word and a 32-bit limit word for every region. Software reaches the block through a coprocessor-style request port. Each request carries a direction, the requester's privilege level, and the four encoding fields op1, crn, crm and op2.

A region can be addressed in two ways. The first is a per-bank selector that steers a shared base/limit window. The second is a direct encoding that names the region in crm and op2. The hypervisor bank also offers two extra registers. One is an enable word, whose bits alias bit 0 of each hypervisor limit word. The other is a read-only word that reports how many regions exist.

Every request gets a registered response one cycle later. The response has read data and a flag that marks the access as undefined. The block does no address matching and no permission evaluation.

Top module: `prot_region_bank`

## Requirements
- R1: After reset every base word, limit word and selector in both banks reads as zero.
- R2: With crn=6, a request whose op1 is 0 (operating-system bank) or 4 (hypervisor bank) reaches these registers: crm=2/op2=1 is the bank's selector (low 8 bits kept, read back zero-extended), crm=3/op2=0 is the base word of the selected region, and crm=3/op2=1 is its limit word.
- R3: With crn=6 and the same op1 per bank, crm[3]=1 and op2[1]=0 reach region i = {crm[2:0], op2[2]} directly, with op2[0]=0 for the base word and op2[0]=1 for the limit word.
- R4: When a bank's selector is at or above the region count, writes through that bank's window are dropped, and reads through it return zero without the undefined flag.
- R5: A direct encoding that names a region at or above the region count is undefined.
- R6: A write to the enable word (op1=4, crn=6, crm=1, op2=1) sets bit 0 of hypervisor limit n to data bit n, for every n below both the region count and 32, and leaves all other limit bits unchanged.
- R7: A read of the enable word returns bit 0 of hypervisor limit n in bit n, for n below the region count; every other bit reads zero.
- R8: The identification word (op1=4, crn=0, crm=0, op2=4) reads as the region count. Writes to it change nothing and are not flagged.
- R9: Operating-system bank registers need privilege 1 or above. Every hypervisor register, including the enable and identification words, needs privilege 2 or above. A request with too little privilege is undefined.
- R10: A request with any other encoding is undefined. An undefined write changes no state, and an undefined read returns zero.
- R11: The response (valid, data, undefined flag) appears exactly one cycle after the request. A write is visible to a read issued in the next cycle.
- R12: The two banks are independent. A write into one bank never changes any word of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_priv | input | 2 | Privilege level of the requester |
| req_op1 | input | 3 | Encoding field op1 (bank select) |
| req_crn | input | 4 | Encoding field crn |
| req_crm | input | 4 | Encoding field crm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_rdata | output | 32 | Read data, zero for writes and undefined accesses |
| rsp_undef | output | 1 | Request was undefined (encoding or privilege) |

## Verification
The bench runs with a region count of 12. This leaves four direct encodings naming absent regions. A design that checks only the encoding shape would accept them and corrupt or read unrelated storage.

Selector values past the count are driven on purpose. A design that lets the selector wrap would then write a real region, where it should drop the write.

Enable-word writes with all 32 bits set show whether the design respects the region count. They must land only below the count, and the other limit bits must stay intact. A design that stores the word as a whole register would break the alias. One that overwrote the full limit word would show it on the next direct read.

Random requests include every privilege level against both banks. A design that puts the identification or enable word under the lower privilege would answer where it should flag an undefined access.

// File: rtl/prb_pkg.sv
package prb_pkg;

  typedef enum logic [2:0] {
    AK_BAD, AK_BASE_WIN, AK_LIM_WIN, AK_SEL,
    AK_BASE_DIR, AK_LIM_DIR, AK_ENABLE, AK_IDENT
  } acc_kind_e;

  localparam logic [2:0] OP1_NORM = 3'd0;
  localparam logic [2:0] OP1_HYP  = 3'd4;
  localparam int         SEL_W    = 8;

  // region number carried by a direct encoding
  function automatic logic [3:0] direct_region(logic [3:0] crm, logic [2:0] op2);
    return {crm[2:0], op2[2]};
  endfunction

  // minimum privilege: 1 for the normal bank, 2 for the hypervisor bank
  function automatic logic priv_sufficient(logic hyp, logic [1:0] priv);
    return hyp ? (priv >= 2'd2) : (priv >= 2'd1);
  endfunction

endpackage

// File: rtl/prb_access_decode.sv
module prb_access_decode
  import prb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [1:0] priv,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output acc_kind_e  kind,
  output logic       hyp,
  output logic [3:0] dir_idx
);
  logic in_bank_space;

  always_comb begin
    hyp           = (op1 == OP1_HYP);
    dir_idx       = direct_region(crm, op2);
    in_bank_space = (crn == 4'd6) && ((op1 == OP1_NORM) || (op1 == OP1_HYP));
    kind          = AK_BAD;
    if (hyp && crn == 4'd0 && crm == 4'd0 && op2 == 3'd4) begin
      kind = AK_IDENT;
    end else if (in_bank_space) begin
      if (crm[3]) begin
        if (!op2[1] && (int'(dir_idx) < N))
          kind = op2[0] ? AK_LIM_DIR : AK_BASE_DIR;
      end else if (crm == 4'd3 && op2 == 3'd0) begin
        kind = AK_BASE_WIN;
      end else if (crm == 4'd3 && op2 == 3'd1) begin
        kind = AK_LIM_WIN;
      end else if (crm == 4'd2 && op2 == 3'd1) begin
        kind = AK_SEL;
      end else if (hyp && crm == 4'd1 && op2 == 3'd1) begin
        kind = AK_ENABLE;
      end
    end
    if (!priv_sufficient(hyp, priv)) kind = AK_BAD;
  end
endmodule

// File: rtl/prb_region_store.sv
module prb_region_store #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic          lim_we,
  input  logic [IW-1:0] idx,
  input  logic [31:0]   wdata,
  input  logic          en_we,
  output logic [31:0]   rd_base,
  output logic [31:0]   rd_lim,
  output logic [N-1:0]  en_bits
);
  logic [31:0] base_q [N];
  logic [31:0] lim_q  [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam logic EN_REACH = (g < 32);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        lim_q[g]  <= '0;
      end else begin
        if (base_we && int'(idx) == g) base_q[g] <= wdata;
        if (lim_we && int'(idx) == g) lim_q[g] <= wdata;
        else if (en_we && EN_REACH) lim_q[g][0] <= wdata[g % 32];
      end
    end
    assign en_bits[g] = lim_q[g][0];
  end

  always_comb begin
    rd_base = '0;
    rd_lim  = '0;
    if (int'(idx) < N) begin
      rd_base = base_q[idx];
      rd_lim  = lim_q[idx];
    end
  end
endmodule

// File: rtl/prot_region_bank.sv
module prot_region_bank
  import prb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_priv,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_undef
);
  localparam int IW     = (N > 1) ? $clog2(N) : 1;
  localparam int EN_TOP = (N < 32) ? N : 32;

  acc_kind_e   kind;
  logic        hyp;
  logic [3:0]  dir_idx;

  prb_access_decode #(.N(N)) u_dec (
    .priv(req_priv), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
    .kind(kind), .hyp(hyp), .dir_idx(dir_idx)
  );

  logic [SEL_W-1:0] sel_norm_q, sel_hyp_q, sel_cur;
  logic             sel_ok, win_access, wr_ok;
  logic [IW-1:0]    ent_idx;
  logic [1:0]       sel_write_ev, base_we, lim_we;
  logic             en_write_ev;

  always_comb begin
    sel_cur    = hyp ? sel_hyp_q : sel_norm_q;
    sel_ok     = int'(sel_cur) < N;
    win_access = (kind == AK_BASE_WIN) || (kind == AK_LIM_WIN);
    ent_idx    = win_access ? IW'(sel_cur) : IW'(dir_idx);
    wr_ok      = req_valid && req_write && (kind != AK_BAD);
    for (int b = 0; b < 2; b++) begin
      sel_write_ev[b] = wr_ok && (kind == AK_SEL) && (hyp == b[0]);
      base_we[b] = wr_ok && (hyp == b[0]) &&
                   ((kind == AK_BASE_DIR) || (kind == AK_BASE_WIN && sel_ok));
      lim_we[b]  = wr_ok && (hyp == b[0]) &&
                   ((kind == AK_LIM_DIR) || (kind == AK_LIM_WIN && sel_ok));
    end
    en_write_ev = wr_ok && (kind == AK_ENABLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_norm_q <= '0;
      sel_hyp_q  <= '0;
    end else begin
      if (sel_write_ev[0]) sel_norm_q <= req_wdata[SEL_W-1:0];
      if (sel_write_ev[1]) sel_hyp_q  <= req_wdata[SEL_W-1:0];
    end
  end

  logic [31:0]  rd_base [2];
  logic [31:0]  rd_lim  [2];
  logic [N-1:0] en_bits [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    prb_region_store #(.N(N), .IW(IW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .base_we(base_we[b]), .lim_we(lim_we[b]), .idx(ent_idx),
      .wdata(req_wdata), .en_we((b == 1) ? en_write_ev : 1'b0),
      .rd_base(rd_base[b]), .rd_lim(rd_lim[b]), .en_bits(en_bits[b])
    );
  end

  logic [31:0] en_word, rd_mux;

  always_comb begin
    en_word = '0;
    for (int n = 0; n < EN_TOP; n++) en_word[n] = en_bits[1][n];
    unique case (kind)
      AK_BASE_WIN: rd_mux = sel_ok ? rd_base[hyp] : '0;
      AK_LIM_WIN:  rd_mux = sel_ok ? rd_lim[hyp]  : '0;
      AK_SEL:      rd_mux = 32'(sel_cur);
      AK_BASE_DIR: rd_mux = rd_base[hyp];
      AK_LIM_DIR:  rd_mux = rd_lim[hyp];
      AK_ENABLE:   rd_mux = en_word;
      AK_IDENT:    rd_mux = 32'(N);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_undef <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_undef <= req_valid && (kind == AK_BAD);
      rsp_rdata <= (req_valid && !req_write && kind != AK_BAD) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/prb_checker.sv
module prb_checker #(
  parameter int N = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_priv,
  input logic [2:0]  req_op1,
  input logic [3:0]  req_crn,
  input logic [3:0]  req_crm,
  input logic [2:0]  req_op2,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_undef,
  input logic [1:0]  sel_write_ev,
  input logic [7:0]  sel_norm_q,
  input logic [7:0]  sel_hyp_q
);
  localparam logic [31:0] EN_MASK = (N >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << N) - 64'd1);

  logic ident_rd, enable_rd;
  assign ident_rd  = req_valid && !req_write && req_priv >= 2'd2 && req_op1 == 3'd4 &&
                     req_crn == 4'd0 && req_crm == 4'd0 && req_op2 == 3'd4;
  assign enable_rd = req_valid && !req_write && req_priv >= 2'd2 && req_op1 == 3'd4 &&
                     req_crn == 4'd6 && req_crm == 4'd1 && req_op2 == 3'd1;

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R9
  norm_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == 2'd0) |=> rsp_undef);
  // R9
  hyp_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op1 == 3'd4 && req_priv < 2'd2) |=> rsp_undef);
  // R10
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_undef |-> (rsp_valid && rsp_rdata == 32'd0));
  // R8
  ident_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ident_rd |=> (rsp_rdata == 32'(N) && !rsp_undef));
  // R7
  enable_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable_rd |=> ((rsp_rdata & ~EN_MASK) == 32'd0));
  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_write_ev[0] |=> $stable(sel_norm_q));
  // R12
  sel_bank_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_write_ev[1] |=> $stable(sel_hyp_q));
endmodule

bind prot_region_bank prb_checker #(.N(N)) u_prb_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_priv(req_priv), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
  .req_op2(req_op2), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_undef(rsp_undef), .sel_write_ev(sel_write_ev),
  .sel_norm_q(sel_norm_q), .sel_hyp_q(sel_hyp_q)
);

// File: tb/test_prot_region_bank.sv
module test_prot_region_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_priv = '0;
  logic [2:0]  req_op1 = '0, req_op2 = '0;
  logic [3:0]  req_crn = '0, req_crm = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_undef;
  logic [31:0] rsp_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] m_base [2][NR];
  logic [31:0] m_lim  [2][NR];
  logic [7:0]  m_sel  [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_region_bank #(.N(NR)) i_prot_region_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_priv(req_priv), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // 0 bad, 1 base window, 2 limit window, 3 selector, 4 base direct,
  // 5 limit direct, 6 enable, 7 ident
  function automatic int classify(int pv, int o1, int cn, int cm, int o2, output int reg_no);
    int k = 0;
    int need;
    reg_no = 0;
    need = (o1 == 4) ? 2 : 1;
    if (o1 == 4 && cn == 0 && cm == 0 && o2 == 4) k = 7;
    else if (cn == 6 && (o1 == 0 || o1 == 4)) begin
      if (cm >= 8) begin
        reg_no = (cm - 8) * 2 + ((o2 >= 4) ? 1 : 0);
        if ((o2 % 4) < 2 && reg_no < NR) k = (o2 % 2 == 1) ? 5 : 4;
      end else if (cm == 3 && o2 == 0) k = 1;
      else if (cm == 3 && o2 == 1) k = 2;
      else if (cm == 2 && o2 == 1) k = 3;
      else if (o1 == 4 && cm == 1 && o2 == 1) k = 6;
    end
    if (pv < need) k = 0;
    return k;
  endfunction

  function automatic string tag_of(int k);
    case (k)
      0: return "R10";
      1, 2, 3: return "R2";
      4, 5: return "R3";
      6: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic access(bit w, int pv, int o1, int cn, int cm, int o2,
                        logic [31:0] wd, string tag);
    int k, r, bk;
    logic [31:0] exp_rd;
    k  = classify(pv, o1, cn, cm, o2, r);
    bk = (o1 == 4) ? 1 : 0;
    exp_rd = '0;
    if (!w) begin
      case (k)
        1: exp_rd = (m_sel[bk] < NR) ? m_base[bk][m_sel[bk]] : '0;
        2: exp_rd = (m_sel[bk] < NR) ? m_lim[bk][m_sel[bk]] : '0;
        3: exp_rd = {24'd0, m_sel[bk]};
        4: exp_rd = m_base[bk][r];
        5: exp_rd = m_lim[bk][r];
        6: for (int n = 0; n < NR && n < 32; n++) exp_rd[n] = m_lim[1][n][0];
        7: exp_rd = NR;
        default: exp_rd = '0;
      endcase
    end else begin
      case (k)
        1: if (m_sel[bk] < NR) m_base[bk][m_sel[bk]] = wd;
        2: if (m_sel[bk] < NR) m_lim[bk][m_sel[bk]] = wd;
        3: m_sel[bk] = wd[7:0];
        4: m_base[bk][r] = wd;
        5: m_lim[bk][r] = wd;
        6: for (int n = 0; n < NR && n < 32; n++) m_lim[1][n][0] = wd[n];
        default: ;
      endcase
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_priv = 2'(pv);
    req_op1 = 3'(o1); req_crn = 4'(cn); req_crm = 4'(cm); req_op2 = 3'(o2);
    req_wdata = wd;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check({tag, " R11 valid"}, {31'd0, rsp_valid}, 32'd1);
    check({tag, " undef"}, {31'd0, rsp_undef}, {31'd0, (k == 0)});
    check({tag, " data"}, rsp_rdata, exp_rd);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      m_sel[b] = '0;
      for (int i = 0; i < NR; i++) begin m_base[b][i] = '0; m_lim[b][i] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 idle valid", {31'd0, rsp_valid}, 32'd0);

    // R1 reset state
    access(0, 1, 0, 6, 2, 1, 0, "R1");
    access(0, 2, 4, 6, 3, 0, 0, "R1");
    access(0, 2, 4, 6, 10, 5, 0, "R1");
    access(0, 2, 4, 6, 1, 1, 0, "R1");
    // R8 identification, write ignored
    access(0, 2, 4, 0, 0, 4, 0, "R8");
    access(1, 3, 4, 0, 0, 4, 32'h55, "R8");
    access(0, 2, 4, 0, 0, 4, 0, "R8");
    access(0, 1, 4, 0, 0, 4, 0, "R9");
    // R2 window and R3 direct view agree; back-to-back for R11
    access(1, 1, 0, 6, 2, 1, 3, "R2");
    access(1, 1, 0, 6, 3, 0, 32'hCAFE_0003, "R2");
    access(0, 1, 0, 6, 9, 4, 0, "R3");
    access(1, 1, 0, 6, 9, 5, 32'h0000_1230, "R3");
    access(0, 1, 0, 6, 3, 1, 0, "R2");
    // R12 other bank untouched
    access(0, 2, 4, 6, 9, 4, 0, "R12");
    access(0, 2, 4, 6, 3, 0, 0, "R12");
    // R6 / R7 enable alias
    access(1, 2, 4, 6, 10, 5, 32'hABCD_0000, "R6");
    access(1, 2, 4, 6, 1, 1, 32'hFFFF_FFFF, "R6");
    access(0, 2, 4, 6, 10, 5, 0, "R6");
    access(0, 2, 4, 6, 1, 1, 0, "R7");
    access(1, 2, 4, 6, 1, 1, 32'h0000_0A5A, "R6");
    access(0, 2, 4, 6, 1, 1, 0, "R7");
    // R4 selector out of range
    access(1, 2, 4, 6, 2, 1, 20, "R4");
    access(1, 2, 4, 6, 3, 0, 32'h1111_2222, "R4");
    access(0, 2, 4, 6, 3, 0, 0, "R4");
    access(1, 2, 4, 6, 2, 1, 11, "R4");
    access(1, 2, 4, 6, 3, 1, 32'h7777_7777, "R4");
    // R5 direct region beyond count
    access(0, 2, 4, 6, 14, 4, 0, "R5");
    access(1, 1, 0, 6, 15, 5, 32'h9, "R5");
    // R10 unknown encodings
    access(0, 2, 4, 5, 3, 0, 0, "R10");
    access(1, 1, 0, 6, 8, 2, 32'h44, "R10");
    access(1, 1, 0, 6, 1, 1, 32'h44, "R10");
    access(0, 1, 2, 6, 3, 0, 0, "R10");
    // R9 privilege
    access(1, 0, 0, 6, 8, 0, 32'hDEAD, "R9");
    access(0, 1, 0, 6, 8, 0, 0, "R9");
    access(1, 1, 4, 6, 8, 0, 32'hBEEF, "R9");
    access(0, 2, 4, 6, 8, 0, 0, "R9");
    idle();
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R11 no request", {31'd0, rsp_valid}, 32'd0);

    void'($urandom(32'h5EED_0001));
    for (int t = 0; t < 3000; t++) begin
      int pv, o1, cn, cm, o2, k, r;
      bit w;
      logic [31:0] wd;
      pv = $urandom % 4;
      o1 = ($urandom % 8 == 0) ? $urandom % 8 : (($urandom % 2) ? 4 : 0);
      cn = ($urandom % 10 == 0) ? $urandom % 16 : 6;
      cm = ($urandom % 3 == 0) ? 8 + $urandom % 8 : $urandom % 4;
      o2 = $urandom % 8;
      if ($urandom % 3 != 0 && cm < 8) o2 = $urandom % 2;
      if ($urandom % 40 == 0) begin o1 = 4; cn = 0; cm = 0; o2 = 4; end
      w  = $urandom % 2;
      wd = $urandom;
      k = classify(pv, o1, cn, cm, o2, r);
      if (k == 3) wd = $urandom % 16;
      access(w, pv, o1, cn, cm, o2, wd, tag_of(k));
      if ($urandom % 16 == 0) idle();
    end
    idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule